// File: doc/BRIEF.md
# Bus-Master Acquisition and Master-Abort Controller

This block is the initiator-side sequencer for a shared parallel bus with a central arbiter. Local logic raises a transfer request together with a burst length. The controller then asserts the bus request and waits for the grant. It takes the bus only after it samples an idle cycle, meaning FRAME and IRDY are both high. It then runs an address phase and the data phases, and ends the burst cleanly. Address and data contents are handled elsewhere. This block owns only the control strobes and their output enable.

Two conditions cut a burst short. If no target claims the transaction within five clocks of FRAME going low, the controller performs a master abort. It raises FRAME first and IRDY one clock later, and it sets a sticky status bit that is cleared by writing 1. If the arbiter withdraws the grant after a latency count, loaded when FRAME first falls, has run out, the data phase in progress becomes the final one and the burst is reported as preempted. A one-cycle done pulse with a status code tells local logic how the burst ended.

Top module: `bus_master_acq`

## Requirements
- R1: After reset, req_n_o, frame_n_o and irdy_n_o are 1, bus_oe, xfer_done and ma_status are 0. Whenever bus_oe is 0, frame_n_o and irdy_n_o are 1.
- R2: With xfer_req high in idle, req_n_o goes low on the next edge and stays low while no grant is sampled. The bus is not driven during this time.
- R3: frame_n_o falls together with bus_oe only on an edge where gnt_n is sampled low, had also been sampled low on the previous edge, and frame_n_i and irdy_n_i are both sampled high. The address phase lasts one cycle with irdy_n_o high. irdy_n_o goes low on the next edge.
- R4: If gnt_n is sampled high before the bus is taken, the bus stays undriven and req_n_o stays low. A fresh grant must be sampled on two edges before FRAME is asserted.
- R5: A data phase completes on an edge where irdy_n_o, trdy_n_i and devsel_n_i are all low. A burst runs exactly xfer_beats data phases, with 0 treated as 1. frame_n_o is high during the final data phase only. IRDY is never released while FRAME is low.
- R6: If none of the first five edges after FRAME falls samples trdy_n_i and devsel_n_i both low, the fifth edge raises frame_n_o and starts an abort. A claim sampled on that fifth edge prevents the abort.
- R7: An abort holds frame_n_o high with irdy_n_o low for exactly one cycle, then raises irdy_n_o.
- R8: A master abort sets ma_status. ma_status stays set until a cycle with ma_clr high, after which it reads 0. A set in the same cycle as a clear wins.
- R9: The latency count loads lat_value when FRAME falls and decrements every clock down to 0. On an edge where the count is 0 and gnt_n is sampled high, the current data phase becomes the final one. With the grant held, the count has no effect.
- R10: A burst ends with xfer_done high for one cycle. In that cycle xfer_status is 00 for complete, 01 for master abort or 10 for preempted with phases left. Also in that cycle req_n_o is 1 and frame_n_o and irdy_n_o are driven high. On the next edge bus_oe is 0 and the controller is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_req | input | 1 | Local transfer request, held until xfer_done |
| xfer_beats | input | BEAT_W | Number of data phases for the burst (0 means 1) |
| lat_value | input | LAT_W | Latency count loaded when FRAME falls |
| ma_clr | input | 1 | Write-1-to-clear strobe for ma_status |
| gnt_n | input | 1 | Arbiter grant, active low |
| frame_n_i | input | 1 | Sampled bus FRAME |
| irdy_n_i | input | 1 | Sampled bus IRDY |
| trdy_n_i | input | 1 | Target ready, active low |
| devsel_n_i | input | 1 | Target claim, active low |
| req_n_o | output | 1 | Bus request, active low |
| frame_n_o | output | 1 | FRAME drive value |
| irdy_n_o | output | 1 | IRDY drive value |
| bus_oe | output | 1 | Output enable for FRAME and IRDY |
| xfer_done | output | 1 | One-cycle end-of-burst pulse |
| xfer_status | output | 2 | End code: 00 complete, 01 abort, 10 preempted |
| ma_status | output | 1 | Sticky master-abort flag |

## Verification
A state machine stuck in or skipping the grant-seen state shows up at once as bus_oe rising without two sampled grant edges, or never rising once the bus goes idle. A wrong response counter moves the edge where frame_n_o rises during an abort off the fifth clock, and a lost claimed flag turns a slow but valid burst into an abort. A bad phase count or latency count shows up as the wrong number of completed phases or the wrong status code at the done pulse, within a few clocks of the point where FRAME should have been released.

// File: rtl/bma_pkg.sv
package bma_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_REQ   = 3'd1,
      ST_GNTD  = 3'd2,
      ST_ADDR  = 3'd3,
      ST_DATA  = 3'd4,
      ST_ABORT = 3'd5,
      ST_TURN  = 3'd6
   } acq_state_t;

   typedef enum logic [1:0] {
      XS_OK      = 2'b00,
      XS_MABORT  = 2'b01,
      XS_PREEMPT = 2'b10
   } xfer_stat_t;

endpackage

// File: rtl/bma_lat_timer.sv
module bma_lat_timer #(
   parameter int LAT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             run,
   input  logic [LAT_W-1:0] load_val,
   output logic             expired
);

   logic [LAT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (run && (cnt_q != '0))
         cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/bma_resp_watch.sv
module bma_resp_watch #(
   parameter int LIMIT = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic active,
   input  logic claim,
   output logic deadline
);

   localparam int CNT_W = (LIMIT > 2) ? $clog2(LIMIT) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

   logic [CNT_W-1:0] cnt_q;
   logic             claimed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         claimed_q <= 1'b0;
      end else if (start) begin
         cnt_q     <= '0;
         claimed_q <= 1'b0;
      end else begin
         if (claim)
            claimed_q <= 1'b1;
         if (active && !claimed_q && (cnt_q != LAST))
            cnt_q <= cnt_q + 1'b1;
      end
   end

   assign deadline = active && !claimed_q && (cnt_q == LAST);

endmodule

// File: rtl/bma_sticky_bit.sv
module bma_sticky_bit #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic flag
);

   logic flag_q;
   logic flag_d;

   generate
      if (SET_WINS) begin : g_set_first
         always_comb begin
            if (set)      flag_d = 1'b1;
            else if (clr) flag_d = 1'b0;
            else          flag_d = flag_q;
         end
      end else begin : g_clr_first
         always_comb begin
            if (clr)      flag_d = 1'b0;
            else if (set) flag_d = 1'b1;
            else          flag_d = flag_q;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= flag_d;
   end

   assign flag = flag_q;

endmodule

// File: rtl/bus_master_acq.sv
module bus_master_acq
   import bma_pkg::*;
#(
   parameter int BEAT_W       = 8,
   parameter int LAT_W        = 8,
   parameter int RESP_TIMEOUT = 5,
   parameter bit HOLD_REQ     = 1'b1,
   parameter bit MA_SET_WINS  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              xfer_req,
   input  logic [BEAT_W-1:0] xfer_beats,
   input  logic [LAT_W-1:0]  lat_value,
   input  logic              ma_clr,
   input  logic              gnt_n,
   input  logic              frame_n_i,
   input  logic              irdy_n_i,
   input  logic              trdy_n_i,
   input  logic              devsel_n_i,
   output logic              req_n_o,
   output logic              frame_n_o,
   output logic              irdy_n_o,
   output logic              bus_oe,
   output logic              xfer_done,
   output logic [1:0]        xfer_status,
   output logic              ma_status
);

   localparam logic [BEAT_W-1:0] ONE_BEAT = BEAT_W'(1);
   localparam logic [BEAT_W-1:0] TWO_BEAT = BEAT_W'(2);

   if (BEAT_W < 2) begin : g_chk_beat
      $error("BEAT_W must be at least 2");
   end
   if (LAT_W < 1) begin : g_chk_lat
      $error("LAT_W must be at least 1");
   end
   if (RESP_TIMEOUT < 2) begin : g_chk_to
      $error("RESP_TIMEOUT must be at least 2");
   end

   acq_state_t        st_q;
   logic              frame_q, irdy_q, oe_q, done_q, req_q;
   xfer_stat_t        stat_q;
   logic [BEAT_W-1:0] left_q;

   logic in_addr, in_data, beat, data_beat, acquire, finish, tx_end;
   logic lat_exp, stop, deadline, drop_req;

   assign in_addr   = (st_q == ST_ADDR);
   assign in_data   = (st_q == ST_DATA);
   assign beat      = !trdy_n_i && !devsel_n_i;
   assign data_beat = in_data && beat;
   assign acquire   = (st_q == ST_GNTD) && !gnt_n && frame_n_i && irdy_n_i;
   assign finish    = data_beat && frame_q;
   assign tx_end    = finish || (st_q == ST_ABORT);
   assign stop      = lat_exp && gnt_n;

   bma_lat_timer #(.LAT_W(LAT_W)) u_lat (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (acquire),
      .run      (in_addr || in_data),
      .load_val (lat_value),
      .expired  (lat_exp)
   );

   bma_resp_watch #(.LIMIT(RESP_TIMEOUT)) u_resp (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (acquire),
      .active   (in_addr || in_data),
      .claim    (data_beat),
      .deadline (deadline)
   );

   bma_sticky_bit #(.SET_WINS(MA_SET_WINS)) u_ma (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (st_q == ST_ABORT),
      .clr   (ma_clr),
      .flag  (ma_status)
   );

   generate
      if (HOLD_REQ) begin : g_req_hold
         assign drop_req = tx_end;
      end else begin : g_req_early
         assign drop_req = tx_end || acquire;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         req_q <= 1'b0;
      else if ((st_q == ST_IDLE) && xfer_req)
         req_q <= 1'b1;
      else if (drop_req)
         req_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         frame_q <= 1'b1;
         irdy_q  <= 1'b1;
         oe_q    <= 1'b0;
         done_q  <= 1'b0;
         stat_q  <= XS_OK;
         left_q  <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (xfer_req) begin
                  st_q   <= ST_REQ;
                  left_q <= (xfer_beats == '0) ? ONE_BEAT : xfer_beats;
               end
            end
            ST_REQ: begin
               if (!gnt_n) st_q <= ST_GNTD;
            end
            ST_GNTD: begin
               if (gnt_n) begin
                  st_q <= ST_REQ;
               end else if (acquire) begin
                  st_q    <= ST_ADDR;
                  frame_q <= 1'b0;
                  oe_q    <= 1'b1;
               end
            end
            ST_ADDR: begin
               st_q   <= ST_DATA;
               irdy_q <= 1'b0;
               if ((left_q == ONE_BEAT) || stop) frame_q <= 1'b1;
            end
            ST_DATA: begin
               if (finish) begin
                  st_q   <= ST_TURN;
                  irdy_q <= 1'b1;
                  done_q <= 1'b1;
                  stat_q <= (left_q > ONE_BEAT) ? XS_PREEMPT : XS_OK;
               end else if (beat) begin
                  left_q <= left_q - 1'b1;
                  if ((left_q == TWO_BEAT) || stop) frame_q <= 1'b1;
               end else if (deadline) begin
                  st_q    <= ST_ABORT;
                  frame_q <= 1'b1;
               end else if (stop) begin
                  frame_q <= 1'b1;
               end
            end
            ST_ABORT: begin
               st_q   <= ST_TURN;
               irdy_q <= 1'b1;
               done_q <= 1'b1;
               stat_q <= XS_MABORT;
            end
            ST_TURN: begin
               st_q <= ST_IDLE;
               oe_q <= 1'b0;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign req_n_o     = !req_q;
   assign frame_n_o   = frame_q;
   assign irdy_n_o    = irdy_q;
   assign bus_oe      = oe_q;
   assign xfer_done   = done_q;
   assign xfer_status = stat_q;

endmodule

// File: rtl/bma_checker.sv
module bma_checker #(
   parameter int RESP_TIMEOUT = 5
) (
   input logic       clk,
   input logic       rst_n,
   input logic       gnt_n,
   input logic       frame_n_i,
   input logic       irdy_n_i,
   input logic       trdy_n_i,
   input logic       devsel_n_i,
   input logic       ma_clr,
   input logic       req_n_o,
   input logic       frame_n_o,
   input logic       irdy_n_o,
   input logic       bus_oe,
   input logic       xfer_done,
   input logic [1:0] xfer_status,
   input logic       ma_status
);

   logic [7:0] ck_cnt;
   logic       ck_claimed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ck_cnt     <= '0;
         ck_claimed <= 1'b0;
      end else if (!bus_oe) begin
         ck_cnt     <= '0;
         ck_claimed <= 1'b0;
      end else begin
         if (ck_cnt != 8'hFF) ck_cnt <= ck_cnt + 1'b1;
         if (!irdy_n_o && !trdy_n_i && !devsel_n_i) ck_claimed <= 1'b1;
      end
   end

   assert_undriven_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_oe |-> (frame_n_o && irdy_n_o));

   assert_take_after_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_oe) |-> (!$past(gnt_n) && !$past(gnt_n, 2) && $past(frame_n_i) && $past(irdy_n_i)
                         && !frame_n_o && irdy_n_o));

   assert_irdy_after_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_oe && $rose(irdy_n_o)) |-> frame_n_o);

   assert_no_claim_timeout_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_oe && !ck_claimed && (ck_cnt >= RESP_TIMEOUT)) |-> frame_n_o);

   assert_abort_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_done && (xfer_status == 2'b01)) |-> (irdy_n_o && $past(frame_n_o) && !$past(irdy_n_o)));

   assert_abort_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_done && (xfer_status == 2'b01)) |-> ma_status);

   assert_sticky_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ma_status) |-> $past(ma_clr));

   assert_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done |=> !bus_oe);

   assert_req_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done |-> (req_n_o && bus_oe && frame_n_o && irdy_n_o));

endmodule

bind bus_master_acq bma_checker #(.RESP_TIMEOUT(RESP_TIMEOUT)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .gnt_n       (gnt_n),
   .frame_n_i   (frame_n_i),
   .irdy_n_i    (irdy_n_i),
   .trdy_n_i    (trdy_n_i),
   .devsel_n_i  (devsel_n_i),
   .ma_clr      (ma_clr),
   .req_n_o     (req_n_o),
   .frame_n_o   (frame_n_o),
   .irdy_n_o    (irdy_n_o),
   .bus_oe      (bus_oe),
   .xfer_done   (xfer_done),
   .xfer_status (xfer_status),
   .ma_status   (ma_status)
);

// File: tb/tb_bus_master_acq.sv
module tb_bus_master_acq;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       xfer_req = 1'b0;
   logic [7:0] xfer_beats = 8'd1;
   logic [7:0] lat_value = 8'd0;
   logic       ma_clr = 1'b0;
   logic       gnt_n = 1'b1;
   logic       other_frame_n = 1'b1;
   logic       trdy_n = 1'b1;
   logic       devsel_n = 1'b1;
   logic       frame_n_i, irdy_n_i;
   logic       req_n_o, frame_n_o, irdy_n_o, bus_oe, xfer_done, ma_status;
   logic [1:0] xfer_status;

   int errors = 0;
   int checks = 0;

   // target model settings (written by tasks)
   int resp_edge = 2;
   bit alt_ready = 1'b0;
   // records (written by monitor only)
   int ek = -1;
   int beat_cnt = 0;
   int frame_hi_beats = 0;
   int fr_ek = -1;
   int ir_ek = -1;
   logic irdy_at_fr = 1'b1;

   always #4 clk = ~clk;

   assign frame_n_i = bus_oe ? frame_n_o : other_frame_n;
   assign irdy_n_i  = bus_oe ? irdy_n_o : 1'b1;

   bus_master_acq dut (
      .clk(clk), .rst_n(rst_n), .xfer_req(xfer_req), .xfer_beats(xfer_beats),
      .lat_value(lat_value), .ma_clr(ma_clr), .gnt_n(gnt_n),
      .frame_n_i(frame_n_i), .irdy_n_i(irdy_n_i), .trdy_n_i(trdy_n),
      .devsel_n_i(devsel_n), .req_n_o(req_n_o), .frame_n_o(frame_n_o),
      .irdy_n_o(irdy_n_o), .bus_oe(bus_oe), .xfer_done(xfer_done),
      .xfer_status(xfer_status), .ma_status(ma_status)
   );

   // target model and phase monitor; ek = edges since FRAME fell
   always @(negedge clk) begin
      if (bus_oe) ek = ek + 1;
      else        ek = -1;
      if (ek == 0) begin
         beat_cnt = 0; frame_hi_beats = 0; fr_ek = -1; ir_ek = -1; irdy_at_fr = 1'b1;
      end
      if (bus_oe && (resp_edge > 0) && (ek >= resp_edge - 1) && (!alt_ready || (ek % 2 == 0))) begin
         trdy_n = 1'b0; devsel_n = 1'b0;
      end else begin
         trdy_n = 1'b1; devsel_n = 1'b1;
      end
      if (bus_oe && !irdy_n_o && !trdy_n && !devsel_n) begin
         beat_cnt = beat_cnt + 1;
         if (frame_n_o) frame_hi_beats = frame_hi_beats + 1;
      end
      if (bus_oe && (ek >= 1) && frame_n_o && (fr_ek < 0)) begin
         fr_ek = ek; irdy_at_fr = irdy_n_o;
      end
      if (bus_oe && (ek >= 2) && irdy_n_o && (ir_ek < 0)) ir_ek = ek;
   end

   task automatic step();
      @(negedge clk); #1;
   endtask

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wait_done();
      int n = 0;
      while (!xfer_done && n < 200) begin step(); n++; end
      chk("R10 done pulse seen", int'(xfer_done), 1);
      xfer_req = 1'b0;
   endtask

   task automatic end_check(input int exp_stat);
      chk("R10 status code", int'(xfer_status), exp_stat);
      chk("R10 req released at done", int'(req_n_o), 1);
      chk("R10 strobes high at done", int'(frame_n_o & irdy_n_o & bus_oe), 1);
      step();
      chk("R10 done lasts one cycle", int'(xfer_done), 0);
      chk("R10 bus released", int'(bus_oe), 0);
      gnt_n = 1'b1;
      step();
   endtask

   task automatic t_reset();
      chk("R1 req_n at reset", int'(req_n_o), 1);
      chk("R1 oe at reset", int'(bus_oe), 0);
      chk("R1 frame/irdy at reset", int'(frame_n_o & irdy_n_o), 1);
      chk("R1 done/ma at reset", int'(xfer_done | ma_status), 0);
   endtask

   task automatic t_single();
      xfer_beats = 8'd1; resp_edge = 2; alt_ready = 0;
      xfer_req = 1'b1;
      step(); step(); step();
      chk("R2 req asserted", int'(req_n_o), 0);
      chk("R2 no drive before grant", int'(bus_oe), 0);
      gnt_n = 1'b0;
      step();
      chk("R3 grant needs second edge", int'(bus_oe), 0);
      step();
      chk("R3 frame taken", int'({bus_oe, frame_n_o, irdy_n_o}), 3'b101);
      step();
      chk("R3 data phase irdy low, frame high for single", int'({frame_n_o, irdy_n_o}), 2'b10);
      wait_done();
      chk("R5 single beat count", beat_cnt, 1);
      end_check(0);
   endtask

   task automatic t_busy();
      xfer_beats = 8'd1; resp_edge = 2; alt_ready = 0;
      other_frame_n = 1'b0; gnt_n = 1'b0; xfer_req = 1'b1;
      for (int i = 0; i < 4; i++) begin
         step();
         chk("R3 wait while bus busy", int'(bus_oe), 0);
      end
      other_frame_n = 1'b1;
      step();
      chk("R3 taken on first idle cycle", int'({bus_oe, frame_n_o}), 2'b10);
      wait_done();
      end_check(0);
   endtask

   task automatic t_withdraw();
      xfer_beats = 8'd1; resp_edge = 2; alt_ready = 0;
      other_frame_n = 1'b0; gnt_n = 1'b0; xfer_req = 1'b1;
      step(); step(); step();
      gnt_n = 1'b1; other_frame_n = 1'b1;
      for (int i = 0; i < 3; i++) begin
         step();
         chk("R4 no drive after grant loss", int'(bus_oe), 0);
         chk("R4 request kept", int'(req_n_o), 0);
      end
      gnt_n = 1'b0;
      step();
      chk("R4 fresh grant first edge", int'(bus_oe), 0);
      step();
      chk("R4 fresh grant second edge", int'(bus_oe), 1);
      wait_done();
      end_check(0);
   endtask

   task automatic t_burst();
      xfer_beats = 8'd4; lat_value = 8'd0; resp_edge = 2; alt_ready = 1;
      gnt_n = 1'b0; xfer_req = 1'b1;
      wait_done();
      chk("R5 burst phase count", beat_cnt, 4);
      chk("R5 frame high only in last phase", frame_hi_beats, 1);
      chk("R9 held grant ignores expired count", int'(xfer_status), 0);
      end_check(0);
   endtask

   task automatic t_claim(input int edge_n, input int exp_abort);
      xfer_beats = 8'd2; lat_value = 8'd40; resp_edge = edge_n; alt_ready = 0;
      gnt_n = 1'b0; xfer_req = 1'b1;
      wait_done();
      if (exp_abort != 0) begin
         chk("R6 frame raised on fifth edge", fr_ek, 5);
         chk("R7 irdy still low when frame rises", int'(irdy_at_fr), 0);
         chk("R7 irdy raised one clock later", ir_ek, 6);
         chk("R8 abort sets flag", int'(ma_status), 1);
         end_check(1);
      end else begin
         chk("R6 claim on fifth edge completes", beat_cnt, 2);
         end_check(0);
      end
   endtask

   task automatic t_clear();
      chk("R8 flag still set after good burst", int'(ma_status), 1);
      ma_clr = 1'b1;
      step();
      ma_clr = 1'b0;
      step();
      chk("R8 write-1 clears flag", int'(ma_status), 0);
   endtask

   task automatic t_latency();
      int n = 0;
      xfer_beats = 8'd8; lat_value = 8'd2; resp_edge = 2; alt_ready = 0;
      gnt_n = 1'b0; xfer_req = 1'b1;
      while (!bus_oe && n < 50) begin step(); n++; end
      gnt_n = 1'b1;
      wait_done();
      chk("R9 phases before preempt", beat_cnt, 3);
      chk("R9 frame raised at expiry", fr_ek, 3);
      end_check(2);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      t_reset();
      rst_n = 1'b1;
      step();
      t_reset();
      t_single();
      t_busy();
      t_withdraw();
      t_burst();
      t_claim(6, 1);
      t_claim(5, 0);
      t_clear();
      t_claim(0, 1);
      t_latency();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule